// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block carries out a single memory access of one, two or four bytes that may begin at any byte address. It works behind a word-wide synchronous memory port whose reads take one cycle. Whatever the offset, it reads the two aligned neighbouring words. For a load, it joins the two words with a funnel shift, picks out the addressed bytes and returns the right-justified value, zero- or sign-extended, together with a one-cycle done pulse.

For a store, it merges the new bytes into both words under two complementary byte masks. It then writes the lower word first and the upper word second. A parameter fixes the byte order. In little-endian mode the byte at the lowest address is the least significant byte of a word and of the value. In big-endian mode it is the most significant byte.

The requester raises a request for one cycle while the engine is idle. Until done, the requester watches busy. Requests that arrive while busy is high are dropped.

Top module: `ua_split_engine`

## Requirements
- R1: During and straight after a synchronous active-low reset, busy, done, mem_rd, mem_wr and rd_data are all zero.
- R2: Every accepted request starts with two reads on consecutive cycles. The first read is at the byte address with its two low bits cleared, and the second is at that address plus 4. This holds even when the address is already aligned.
- R3: When BIG_ENDIAN is 0, a load returns the addressed bytes with the lowest-address byte in bits 7:0 and each following byte in the next 8 bits up.
- R4: When BIG_ENDIAN is 1, a load returns the addressed bytes with the lowest-address byte as the most significant byte of the value. Within a memory word, the byte at offset k sits in bits 31-8k down to 24-8k.
- R5: req_size encodes the access width: 0 selects one byte, 1 selects two bytes, and 2 or 3 selects four bytes. A one-byte load is zero-extended to 32 bits. req_signed has no effect on one-byte and four-byte loads.
- R6: For a two-byte load, bits 31:16 of rd_data are zero when req_signed is 0. When req_signed is 1, they are copies of bit 15.
- R7: A store changes only the addressed bytes of memory, in the byte order chosen by BIG_ENDIAN. It writes the word at the aligned base first and the word at base+4 on the next cycle, and it never reads and writes in the same cycle.
- R8: Busy rises on the cycle after a request is accepted. A load raises done three clock edges after the accepting edge, and a store raises it four edges after. Done is a one-cycle pulse while busy is low, and rd_data is valid while done is high.
- R9: A request presented while busy is high is ignored: it causes no memory access and does not change the result of the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Width code: 0 byte, 1 two bytes, 2/3 four bytes |
| req_signed | input | 1 | Sign-extend a two-byte load |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | DATA_W | Store value, right-justified |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Load result, held until the next load completes |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_rd |

## Verification
The bench builds the engine twice from identical stimulus: one copy with BIG_ENDIAN=0 and one with BIG_ENDIAN=1. Each copy has its own word memory, and a byte-array model predicts every result. Both funnel-shift and mask directions, and both lane mappings, are therefore exercised against all four byte offsets, all three widths and both signedness settings. Widths stay at 32-bit data and 32-bit addresses. The bench also covers store round-trips and a request that collides with a busy engine.

// File: rtl/ua_split_pkg.sv
// Shared types for the misaligned access splitter.
package ua_split_pkg;

    // Access width code as seen on req_size.
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WRD2 = 2'd3
    } acc_size_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_LO  = 3'd1,
        ST_RD_HI  = 3'd2,
        ST_LD_FIN = 3'd3,
        ST_WR_LO  = 3'd4,
        ST_WR_HI  = 3'd5
    } eng_state_e;

    // Latched attributes of the access in flight.
    typedef struct packed {
        acc_size_e size;
        logic      sgn;
        logic      wr;
    } acc_cmd_t;

endpackage

// File: rtl/ua_split_funnel.sv
// Load path: joins the lower and upper aligned words, shifts the addressed
// bytes into place and extends the result to DATA_W.
// Assumes DATA_W is a multiple of 16 and lo_word/hi_word are the words at
// base and base+DATA_W/8.
module ua_split_funnel
    import ua_split_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int OFF_W     = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              sgn,
    output logic [DATA_W-1:0] value
);
    timeunit 1ns; timeprecision 1ps;

    localparam int SH_W = OFF_W + 3;

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] rj;

    assign sh = {off, 3'b000};

    // Endianness picks the funnel direction and where narrow values start.
    generate
        if (BIG_ENDIAN) begin : g_be
            logic [DATA_W-1:0] top;
            // Lowest-address byte moves to the top of the window.
            assign top = DATA_W'(({lo_word, hi_word} << sh) >> DATA_W);
            // Right-justify narrow values that start at the top.
            always_comb begin
                case (size)
                    ACC_BYTE: rj = top >> (DATA_W - 8);
                    ACC_HALF: rj = top >> (DATA_W - 16);
                    default:  rj = top;
                endcase
            end
        end else begin : g_le
            // Lowest-address byte moves to the bottom of the window.
            assign rj = DATA_W'({hi_word, lo_word} >> sh);
        end
    endgenerate

    // Width selection and extension.
    always_comb begin
        case (size)
            ACC_BYTE: value = {{(DATA_W-8){1'b0}}, rj[7:0]};
            ACC_HALF: value = {{(DATA_W-16){sgn & rj[15]}}, rj[15:0]};
            default:  value = rj;
        endcase
    end

endmodule

// File: rtl/ua_split_merge.sv
// Store path: places the store value at its byte offset across two words
// and merges it into the old contents under complementary byte masks.
// Assumes lo_old/hi_old hold the current words at base and base+DATA_W/8.
module ua_split_merge
    import ua_split_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int OFF_W     = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] lo_old,
    input  logic [DATA_W-1:0] hi_old,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] lo_new,
    output logic [DATA_W-1:0] hi_new
);
    timeunit 1ns; timeprecision 1ps;

    localparam int SH_W = OFF_W + 3;
    localparam int DW2  = 2 * DATA_W;

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] smask;
    logic [DATA_W-1:0] lo_d, hi_d, lo_m, hi_m;

    assign sh = {off, 3'b000};

    // Right-justified mask of the bytes being written.
    always_comb begin
        case (size)
            ACC_BYTE: smask = {{(DATA_W-8){1'b0}}, 8'hFF};
            ACC_HALF: smask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default:  smask = '1;
        endcase
    end

    // Endianness picks which end of the pair the value enters from.
    generate
        if (BIG_ENDIAN) begin : g_be
            logic [DATA_W-1:0] vl, ml;
            logic [DW2-1:0]    pd, pm;
            // Left-justify value and mask by the access width.
            always_comb begin
                case (size)
                    ACC_BYTE: begin vl = wdata << (DATA_W - 8);  ml = smask << (DATA_W - 8);  end
                    ACC_HALF: begin vl = wdata << (DATA_W - 16); ml = smask << (DATA_W - 16); end
                    default:  begin vl = wdata;                  ml = smask;                  end
                endcase
            end
            assign pd = {vl, {DATA_W{1'b0}}} >> sh;
            assign pm = {ml, {DATA_W{1'b0}}} >> sh;
            assign lo_d = pd[DW2-1:DATA_W];
            assign hi_d = pd[DATA_W-1:0];
            assign lo_m = pm[DW2-1:DATA_W];
            assign hi_m = pm[DATA_W-1:0];
        end else begin : g_le
            logic [DW2-1:0] pd, pm;
            assign pd = {{DATA_W{1'b0}}, wdata & smask} << sh;
            assign pm = {{DATA_W{1'b0}}, smask} << sh;
            assign lo_d = pd[DATA_W-1:0];
            assign hi_d = pd[DW2-1:DATA_W];
            assign lo_m = pm[DATA_W-1:0];
            assign hi_m = pm[DW2-1:DATA_W];
        end
    endgenerate

    // Keep old bytes outside the mask, insert new bytes inside it.
    assign lo_new = (lo_old & ~lo_m) | (lo_d & lo_m);
    assign hi_new = (hi_old & ~hi_m) | (hi_d & hi_m);

endmodule

// File: rtl/ua_split_ctrl.sv
// Sequencer: accepts one request when idle, issues the two aligned reads,
// then either finishes a load or writes the two merged words.
// Assumes the memory returns read data one cycle after mem_rd.
module ua_split_ctrl
    import ua_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] ld_value,
    input  logic [DATA_W-1:0] st_lo,
    input  logic [DATA_W-1:0] st_hi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output acc_cmd_t          cmd,
    output logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo_word,
    output logic [DATA_W-1:0] hi_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);
    timeunit 1ns; timeprecision 1ps;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

    eng_state_e        state_q;
    acc_cmd_t          cmd_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wdata_q, lo_q, hi_q, rd_q;
    logic              done_q;

    // State, latched request and captured words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            off_q   <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    cmd_q   <= '{size: acc_size_e'(req_size), sgn: req_signed, wr: req_write};
                    off_q   <= req_addr[OFF_W-1:0];
                    base_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                    wdata_q <= req_wdata;
                    state_q <= ST_RD_LO;
                end
                ST_RD_LO:  state_q <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_q    <= mem_rdata;
                    state_q <= cmd_q.wr ? ST_WR_LO : ST_LD_FIN;
                end
                ST_LD_FIN: begin
                    rd_q    <= ld_value;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_WR_LO: begin
                    hi_q    <= mem_rdata;
                    state_q <= ST_WR_HI;
                end
                ST_WR_HI: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive from the current state.
    always_comb begin
        mem_rd    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        mem_wr    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        mem_addr  = ((state_q == ST_RD_HI) || (state_q == ST_WR_HI)) ? base_q + STEP : base_q;
        mem_wdata = (state_q == ST_WR_HI) ? st_hi : st_lo;
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
    assign cmd     = cmd_q;
    assign off     = off_q;
    assign wdata   = wdata_q;
    assign lo_word = lo_q;
    assign hi_word = hi_q;

    // The second read follows the first, one word higher.
    assert_rd_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_LO) |=> (mem_rd && mem_addr == $past(mem_addr) + STEP));

    // The upper write follows the lower one, one word higher.
    assert_wr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_LO) |=> (mem_wr && mem_addr == $past(mem_addr) + STEP));

    // Never a read and a write on the same cycle.
    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // Done lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // The end of busy is always marked by done.
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // A request while busy leaves the latched access untouched.
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(base_q) && $stable(cmd_q) && $stable(wdata_q)));

endmodule

// File: rtl/ua_split_engine.sv
// Top level of the misaligned access splitter: sequencer plus the load
// funnel and store merge datapaths.
// Assumes a word-wide memory with one-cycle read latency and one
// requester that waits for done before relying on results.
module ua_split_engine
    import ua_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    timeunit 1ns; timeprecision 1ps;

    localparam int OFF_W = $clog2(DATA_W / 8);

    acc_cmd_t          cmd;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] wdata, lo_word, hi_word, ld_value, st_lo, st_hi;

    ua_split_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_signed(req_signed), .req_write(req_write), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .ld_value(ld_value), .st_lo(st_lo), .st_hi(st_hi),
        .busy(busy), .done(done), .rd_data(rd_data),
        .cmd(cmd), .off(off), .wdata(wdata), .lo_word(lo_word), .hi_word(hi_word),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    // Upper word is taken straight from the port on the finishing cycle.
    ua_split_funnel #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_funnel (
        .lo_word(lo_word), .hi_word(mem_rdata), .off(off),
        .size(cmd.size), .sgn(cmd.sgn), .value(ld_value)
    );

    ua_split_merge #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_merge (
        .lo_old(lo_word), .hi_old(hi_word), .wdata(wdata), .off(off),
        .size(cmd.size), .lo_new(st_lo), .hi_new(st_hi)
    );

    // A finished one-byte load carries nothing above bit 7.
    assert_byte_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd.wr && cmd.size == ACC_BYTE) |-> (rd_data[DATA_W-1:8] == '0));

    // An unsigned two-byte load carries nothing above bit 15.
    assert_half_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd.wr && cmd.size == ACC_HALF && !cmd.sgn) |-> (rd_data[DATA_W-1:16] == '0));

    // Completion is never reported while the engine is still busy.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/ua_split_engine_tb.sv
// Directed bench: one little-endian and one big-endian engine run the same
// requests, each against its own word memory and a byte-level model.
module ua_split_engine_tb;
    timeunit 1ns; timeprecision 1ps;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [1:0]    req_size  = '0;
    logic          req_signed = 1'b0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;

    logic busy_l, done_l, mrd_l, mwr_l, busy_b, done_b, mrd_b, mwr_b;
    logic [DW-1:0] rdata_l, mwd_l, mrdata_l, rdata_b, mwd_b, mrdata_b;
    logic [AW-1:0] maddr_l, maddr_b;

    logic [31:0] mem_l [NW];
    logic [31:0] mem_b [NW];
    logic [31:0] exp_l [NW];
    logic [31:0] exp_b [NW];

    int n_chk = 0;
    int n_bad = 0;
    int lat;
    int n_rd, n_wr;
    int log_rd [4];
    int log_wr [4];

    ua_split_engine #(.ADDR_W(AW), .DATA_W(DW), .BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy_l), .done(done_l), .rd_data(rdata_l),
        .mem_addr(maddr_l), .mem_rd(mrd_l), .mem_wr(mwr_l), .mem_wdata(mwd_l),
        .mem_rdata(mrdata_l));

    ua_split_engine #(.ADDR_W(AW), .DATA_W(DW), .BIG_ENDIAN(1'b1)) u_dut_be (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy_b), .done(done_b), .rd_data(rdata_b),
        .mem_addr(maddr_b), .mem_rd(mrd_b), .mem_wr(mwr_b), .mem_wdata(mwd_b),
        .mem_rdata(mrdata_b));

    function automatic logic [31:0] init_word(int i);
        logic [31:0] k;
        k = i;
        return 32'h8D3A_51C6 ^ (k * 32'h01F3_A7B9);
    endfunction

    // Word memories with one-cycle read latency, reloaded during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                mem_l[i] <= init_word(i);
                mem_b[i] <= init_word(i);
            end
            mrdata_l <= '0;
            mrdata_b <= '0;
        end else begin
            if (mwr_l) mem_l[maddr_l[5:2]] <= mwd_l;
            if (mrd_l) mrdata_l <= mem_l[maddr_l[5:2]];
            if (mwr_b) mem_b[maddr_b[5:2]] <= mwd_b;
            if (mrd_b) mrdata_b <= mem_b[maddr_b[5:2]];
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(bit be, int a);
        logic [31:0] w;
        int lane;
        w = be ? exp_b[a / 4] : exp_l[a / 4];
        lane = be ? 3 - (a % 4) : a % 4;
        return w[lane*8 +: 8];
    endfunction

    task automatic set_byte(bit be, int a, logic [7:0] b);
        int lane;
        lane = be ? 3 - (a % 4) : a % 4;
        if (be) exp_b[a / 4][lane*8 +: 8] = b;
        else    exp_l[a / 4][lane*8 +: 8] = b;
    endtask

    function automatic int nbytes(int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ref_load(bit be, int a, int sz, bit sgn);
        logic [31:0] acc;
        int nb;
        nb = nbytes(sz);
        acc = '0;
        for (int k = 0; k < nb; k++) begin
            if (be) acc = (acc << 8) | 32'(exp_byte(be, a + k));
            else    acc = acc | (32'(exp_byte(be, a + k)) << (8 * k));
        end
        if (nb == 2 && sgn && acc[15]) acc[31:16] = 16'hFFFF;
        return acc;
    endfunction

    task automatic model_store(int a, int sz, logic [31:0] wd);
        int nb;
        nb = nbytes(sz);
        for (int k = 0; k < nb; k++) begin
            set_byte(1'b0, a + k, wd[8*k +: 8]);
            set_byte(1'b1, a + k, wd[8*(nb-1-k) +: 8]);
        end
    endtask

    // Issue one request, log memory traffic, wait for done.
    task automatic run_req(int a, int sz, bit sgn, bit wr, logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_size = 2'(sz);
        req_signed = sgn; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; n_rd = 0; n_wr = 0;
        while (!done_l && lat < 20) begin
            if (mrd_l && n_rd < 4) begin log_rd[n_rd] = int'(maddr_l); n_rd++; end
            if (mwr_l && n_wr < 4) begin log_wr[n_wr] = int'(maddr_l); n_wr++; end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic chk_mem(string req);
        logic [31:0] al, el, ab, eb;
        al = '0; el = '0; ab = '0; eb = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (mem_l[i] !== exp_l[i]) begin al = mem_l[i]; el = exp_l[i]; end
            if (mem_b[i] !== exp_b[i]) begin ab = mem_b[i]; eb = exp_b[i]; end
        end
        chk(req, "memory little-endian", al, el);
        chk(req, "memory big-endian", ab, eb);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) begin exp_l[i] = init_word(i); exp_b[i] = init_word(i); end
        repeat (3) @(negedge clk);
        chk("R1", "busy/done/rd/wr in reset", {28'd0, busy_l | busy_b, done_l | done_b,
            mrd_l | mrd_b, mwr_l | mwr_b}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "controls after reset", {28'd0, busy_l | busy_b, done_l | done_b,
            mrd_l | mrd_b, mwr_l | mwr_b}, 32'd0);
        chk("R1", "rd_data after reset", rdata_l | rdata_b, 32'd0);
    endtask

    task automatic t_loads();
        for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++)
                for (int s = 0; s < 2; s++) begin
                    int a;
                    a = 4 * (off + 2 * sz + 1) + off;
                    run_req(a, sz, s[0], 1'b0, 32'd0);
                    chk("R8", "load latency", 32'(lat), 32'd3);
                    chk("R8", "done on both", {31'd0, done_b}, 32'd1);
                    chk("R2", "read count", 32'(n_rd), 32'd2);
                    chk("R2", "first read addr", 32'(log_rd[0]), 32'(a & ~3));
                    chk("R2", "second read addr", 32'(log_rd[1]), 32'((a & ~3) + 4));
                    if (sz == 1) begin
                        chk("R6", "two-byte load LE", rdata_l, ref_load(1'b0, a, sz, s[0]));
                        chk("R6", "two-byte load BE", rdata_b, ref_load(1'b1, a, sz, s[0]));
                    end else begin
                        chk("R5", "byte/word load, sign flag ignored", rdata_l,
                            ref_load(1'b0, a, sz, 1'b0));
                        chk("R3", "load little-endian", rdata_l, ref_load(1'b0, a, sz, s[0]));
                        chk("R4", "load big-endian", rdata_b, ref_load(1'b1, a, sz, s[0]));
                    end
                    @(negedge clk);
                    chk("R8", "done single pulse", {31'd0, done_l | done_b}, 32'd0);
                end
    endtask

    task automatic t_stores();
        for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++) begin
                int a;
                logic [31:0] wd;
                a = 4 * (3 * off + sz + 1) + off;
                wd = 32'hF1E2_D3C4 ^ (32'(sz) << 28) ^ (32'(off) * 32'h0101_0101);
                run_req(a, sz, 1'b0, 1'b1, wd);
                model_store(a, sz, wd);
                chk("R8", "store latency", 32'(lat), 32'd4);
                chk("R7", "write count", 32'(n_wr), 32'd2);
                chk("R7", "lower word written first", 32'(log_wr[0]), 32'(a & ~3));
                chk("R7", "upper word written second", 32'(log_wr[1]), 32'((a & ~3) + 4));
                chk("R2", "store read count", 32'(n_rd), 32'd2);
                chk_mem("R7");
                run_req(a, sz, 1'b0, 1'b0, 32'd0);
                chk("R3", "store round trip LE", rdata_l, ref_load(1'b0, a, sz, 1'b0));
                chk("R4", "store round trip BE", rdata_b, ref_load(1'b1, a, sz, 1'b0));
            end
    endtask

    task automatic t_busy_ignore();
        int seen;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'd21; req_size = 2'd2;
        req_signed = 1'b0; req_write = 1'b0; req_wdata = '0;
        @(negedge clk);
        req_addr = 32'd42; req_size = 2'd1; req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
        lat = 0; n_wr = 0;
        repeat (2) begin
            if (mwr_l) n_wr++;
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        while (!done_l && lat < 20) begin
            if (mwr_l) n_wr++;
            @(negedge clk);
            lat++;
        end
        chk("R9", "load latency with colliding request", 32'(lat), 32'd3);
        chk("R9", "result LE unchanged", rdata_l, ref_load(1'b0, 21, 2, 1'b0));
        chk("R9", "result BE unchanged", rdata_b, ref_load(1'b1, 21, 2, 1'b0));
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (busy_l || busy_b || mwr_l || mwr_b || mrd_l || mrd_b) seen++;
        end
        chk("R9", "no access after ignored request", 32'(seen + n_wr), 32'd0);
        chk_mem("R9");
    endtask

    initial begin
        t_reset();
        t_loads();
        t_stores();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual hang expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule